// File: doc/BRIEF.md
# Radix-4 Booth Partial Product Generator

This block prepares the partial products for the 24 x 24-bit unsigned significand multiply inside a single-precision multiplier. It takes the two 23-bit fraction fields, puts back the implicit leading one on each, recodes the multiplier significand into radix-4 signed digits, and emits one partial-product row per digit. The rows are already shifted to their weights in a 48-bit product frame. The rows can be summed with plain adders: each row carries a short sign prefix built from its digit sign, so no sign bits are replicated across the full width. The +1 of each negated row sits as a single bit in the row above it.

Row formation is combinational. A row register, cleared by a synchronous active-high reset, closes the first pipeline stage. A downstream reduction tree consumes the registered rows. Exponent arithmetic, row reduction and rounding belong to other blocks.

Top module: `bpp_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, every bit of `rows_q` becomes 0 at that edge.
- R2: `rows_q` updates only at a rising clock edge. After an edge with `rst` low, it holds the rows for the `frac_a`/`frac_b` values sampled at that edge, so the latency is one cycle.
- R3: Take the 13 rows of 48 bits and add them modulo 2^48. The total equals {1,`frac_a`} x {1,`frac_b`}.
- R4: The multiplier X = {2'b00, 1, `frac_b`, 0} is 27 bits wide. Digit k (k = 0..12) is read from X[2k+2:2k] as -2*X[2k+2] + X[2k+1] + X[2k]. Row k belongs to digit k, and row k occupies `rows_q[48k+47:48k]`.
- R5: Let A = {1,`frac_a`}. Bits [2k+25:2k] of row k hold a 26-bit field, truncated above bit 47. The field is A for digit +/-1, 2A for digit +/-2, and 0 for digit 0. For a negative digit, the field is inverted bitwise.
- R6: A zero digit (group 000 or 111) is treated as positive. Its field is all zeros, and its prefix shows the sign as 0: row 0 bits [28:26] = 100, and row k>0 bits [2k+27:2k+26] = 11.
- R7: For k>=1, bit 2k-2 of row k is 1 exactly when digit k-1 is negative. All other bits of row k below 2k are 0. Row 0 has no such bit.
- R8: The prefix is built from the digit sign n. Row 0 bits [28:26] = {~n, n, n}. Row k>0 bits [2k+27:2k+26] = {1, ~n}. Prefix bits above bit 47 are dropped.
- R9: Digit 12 is always +1, because its group is {0,0,1}. So row 12 bits [47:24] equal A, and bits [21:0] of row 12 are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the row register |
| frac_a | input | 23 | Multiplicand fraction field (implicit one restored inside) |
| frac_b | input | 23 | Multiplier fraction field (implicit one restored inside) |
| rows_q | output | 624 | 13 registered rows of 48 bits; row k in bits [48k+47:48k] |

## Verification
The bound checker watches several properties on every clock after reset:
- the modular sum of the rows against the significand product;
- the cleared low bits and the negation carry bit of each row;
- the zero-digit field and its positive prefix;
- the top row always holding the multiplicand;
- clearing of the rows on reset.

Only the bench scenarios show the following:
- the exact field and prefix contents of negative digits, and their +2 versus +1 selection, against a behavioural model;
- that the outputs hold between edges;
- a reset that arrives in mid-stream.

The multiplier patterns are chosen to produce every digit code: alternating bits, repeating 011 and 001 groups, all ones, all zeros and walking ones. Random operands then cover the mixed cases.

// File: rtl/bpp_pkg.sv
package bpp_pkg;

  // Radix-4 digit: sign plus one-hot magnitude select.
  typedef struct packed {
    logic neg;
    logic sel_two;
    logic sel_one;
    logic sel_zero;
  } bdig_t;

endpackage

// File: rtl/bpp_digit_enc.sv
// Recodes one overlapping 3-bit multiplier group into a signed digit.
module bpp_digit_enc
  import bpp_pkg::*;
(
  input  logic [2:0] grp,
  output bdig_t      dig
);

  logic hi_x, lo_x;

  always_comb begin
    hi_x         = grp[2] ^ grp[1];
    lo_x         = grp[1] ^ grp[0];
    dig.sel_one  = lo_x;
    dig.sel_two  = hi_x & ~lo_x;
    dig.sel_zero = ~hi_x & ~lo_x;
    // A zero digit is always reported as positive.
    dig.neg      = grp[2] & ~dig.sel_zero;
  end

endmodule

// File: rtl/bpp_row.sv
// Builds the body of one aligned row: the selected (and possibly inverted)
// multiplicand field plus its compact sign prefix. The +1 of a negated
// row is placed by the parent into the row above.
module bpp_row
  import bpp_pkg::*;
#(
  parameter int MC_W   = 25,
  parameter int PROD_W = 48,
  parameter int IDX    = 0
) (
  input  logic [MC_W-1:0]   mcand,
  input  bdig_t             dig,
  output logic [PROD_W-1:0] row
);

  localparam int FLD_W = MC_W + 1;
  localparam int LOC_W = FLD_W + 3;
  localparam int SH    = 2 * IDX;

  logic [FLD_W-1:0] mag;
  logic [FLD_W-1:0] fld;
  logic [LOC_W-1:0] loc;

  always_comb begin
    unique case ({dig.sel_two, dig.sel_one, dig.sel_zero})
      3'b010:  mag = {1'b0, mcand};
      3'b100:  mag = {mcand, 1'b0};
      default: mag = '0;
    endcase
    fld = dig.neg ? ~mag : mag;
  end

  generate
    if (IDX == 0) begin : g_first
      assign loc = {~dig.neg, dig.neg, dig.neg, fld};
    end else begin : g_rest
      assign loc = {1'b0, 1'b1, ~dig.neg, fld};
    end
  endgenerate

  assign row = {{(PROD_W-LOC_W){1'b0}}, loc} << SH;

endmodule

// File: rtl/bpp_gen.sv
// Radix-4 Booth row generator for the significand product of two
// single-precision operands, with a registered row bank. The default
// fraction width must be odd so the significand width stays even.
module bpp_gen
  import bpp_pkg::*;
#(
  parameter  int FRAC_W = 23,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int PROD_W = 2 * SIG_W,
  localparam int NROW   = SIG_W / 2 + 1,
  localparam int MR_W   = 2 * NROW + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [FRAC_W-1:0]      frac_a,
  input  logic [FRAC_W-1:0]      frac_b,
  output logic [NROW*PROD_W-1:0] rows_q
);

  localparam int MC_W = SIG_W + 1;

  logic [MC_W-1:0]        mcand;
  logic [MR_W-1:0]        mplr;
  bdig_t                  dig  [NROW];
  logic [PROD_W-1:0]      body [NROW];
  logic [NROW*PROD_W-1:0] rows_d;

  // Multiplicand forced non-negative, multiplier padded for recoding.
  assign mcand = {1'b0, 1'b1, frac_a};
  assign mplr  = {2'b00, 1'b1, frac_b, 1'b0};

  generate
    for (genvar k = 0; k < NROW; k++) begin : g_row
      bpp_digit_enc u_enc (
        .grp (mplr[2*k +: 3]),
        .dig (dig[k])
      );

      bpp_row #(
        .MC_W   (MC_W),
        .PROD_W (PROD_W),
        .IDX    (k)
      ) u_row (
        .mcand (mcand),
        .dig   (dig[k]),
        .row   (body[k])
      );

      if (k == 0) begin : g_base
        assign rows_d[0 +: PROD_W] = body[0];
      end else begin : g_carry
        // Negation +1 of the row below, dropped into this row's spare slot.
        assign rows_d[k*PROD_W +: PROD_W] =
          body[k] | (PROD_W'(dig[k-1].neg) << (2*k - 2));
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) rows_q <= '0;
    else     rows_q <= rows_d;
  end

endmodule

// File: rtl/bpp_gen_chk.sv
module bpp_gen_chk #(
  parameter int FRAC_W = 23,
  parameter int SIG_W  = 24,
  parameter int PROD_W = 48,
  parameter int NROW   = 13
) (
  input logic                   clk,
  input logic                   rst,
  input logic [FRAC_W-1:0]      frac_a,
  input logic [FRAC_W-1:0]      frac_b,
  input logic [NROW*PROD_W-1:0] rows_q
);

  localparam int XW = 2 * NROW + 1;

  logic [PROD_W-1:0] prod_now;
  logic [PROD_W-1:0] row_sum;
  logic [XW-1:0]     xm;

  assign prod_now = PROD_W'({1'b1, frac_a}) * PROD_W'({1'b1, frac_b});
  assign xm       = {2'b00, 1'b1, frac_b, 1'b0};

  always_comb begin
    row_sum = '0;
    for (int k = 0; k < NROW; k++) row_sum = row_sum + rows_q[k*PROD_W +: PROD_W];
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (rows_q == '0));

  // R3 (also covers the one-cycle latency of R2)
  a_r3_sum_matches: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (row_sum == $past(prod_now)));

  // R9
  a_r9_top_row: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (rows_q[(NROW-1)*PROD_W + 2*(NROW-1) +: SIG_W] == $past({1'b1, frac_a})));

  generate
    for (genvar k = 1; k < NROW; k++) begin : g_low
      // R7: only the carry slot may be set below the row's weight
      a_r7_low_clear: assert property (@(posedge clk) disable iff (rst)
        (rows_q[k*PROD_W + 2*k - 1] == 1'b0) &&
        ((rows_q[k*PROD_W +: PROD_W] & ((PROD_W'(1) << (2*k - 2)) - PROD_W'(1))) == '0));

      // R7: carry slot mirrors the sign of the digit below
      a_r7_neg_carry: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rows_q[k*PROD_W + 2*k - 2] ==
                  $past(xm[2*k] & ~(xm[2*k-1] & xm[2*k-2]))));
    end

    for (genvar k = 0; 2*k + SIG_W + 4 < PROD_W; k++) begin : g_zero
      // R6: zero digit gives an empty field and a positive prefix
      if (k == 0) begin : g_z0
        a_r6_zero_row: assert property (@(posedge clk) disable iff (rst)
          ((xm[2:0] == 3'b000) || (xm[2:0] == 3'b111)) |=>
          (rows_q[0 +: SIG_W+5] == {3'b100, {(SIG_W+2){1'b0}}}));
      end else begin : g_zk
        a_r6_zero_row: assert property (@(posedge clk) disable iff (rst)
          ((xm[2*k +: 3] == 3'b000) || (xm[2*k +: 3] == 3'b111)) |=>
          (rows_q[k*PROD_W + 2*k +: SIG_W+4] == {2'b11, {(SIG_W+2){1'b0}}}));
      end
    end
  endgenerate

endmodule

bind bpp_gen bpp_gen_chk #(
  .FRAC_W (FRAC_W),
  .SIG_W  (SIG_W),
  .PROD_W (PROD_W),
  .NROW   (NROW)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .frac_a (frac_a),
  .frac_b (frac_b),
  .rows_q (rows_q)
);

// File: tb/bpp_gen_tb.sv
`timescale 1ns/1ps
module bpp_gen_tb;

  localparam int FRAC_W = 23;
  localparam int PROD_W = 48;
  localparam int NROW   = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [FRAC_W-1:0] fa = '0;
  logic [FRAC_W-1:0] fb = '0;
  logic [NROW*PROD_W-1:0] rows;

  int  n_chk = 0;
  int  n_err = 0;
  bit  done  = 0;
  logic [2*FRAC_W-1:0] pend [$];

  always #4 clk = ~clk;

  bpp_gen #(.FRAC_W(FRAC_W)) u_dut (
    .clk    (clk),
    .rst    (rst),
    .frac_a (fa),
    .frac_b (fb),
    .rows_q (rows)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  // R4: digit value from the padded multiplier
  function automatic int digit(input logic [FRAC_W-1:0] b, input int k);
    logic [26:0] x;
    x = {2'b00, 1'b1, b, 1'b0};
    return -2 * int'(x[2*k+2]) + int'(x[2*k+1]) + int'(x[2*k]);
  endfunction

  // R5/R6/R7/R8: expected row from arithmetic on the digit value
  function automatic logic [PROD_W-1:0] exp_row(input logic [FRAC_W-1:0] a, input logic [FRAC_W-1:0] b, input int k);
    longint      av;
    longint      v;
    int          d;
    logic [63:0] r;
    av = longint'({1'b1, a});
    d  = digit(b, k);
    v  = d * av;
    r  = (d < 0) ? (64'(v - 1) & 64'h3FF_FFFF) : 64'(v);
    if (k == 0) r = r | (((d < 0) ? 64'h3 : 64'h4) << 26);
    else        r = r | (((d < 0) ? 64'h2 : 64'h3) << 26);
    r = r << (2*k);
    if (k > 0 && digit(b, k-1) < 0) r = r | (64'd1 << (2*k - 2));
    return r[PROD_W-1:0];
  endfunction

  function automatic logic [PROD_W-1:0] fmask(input int k);
    logic [63:0] m;
    m = 64'h3FF_FFFF << (2*k);
    return m[PROD_W-1:0];
  endfunction

  function automatic logic [PROD_W-1:0] pmask(input int k);
    logic [63:0] m;
    m = ((k == 0) ? 64'h7 : 64'h3) << (26 + 2*k);
    return m[PROD_W-1:0];
  endfunction

  function automatic logic [PROD_W-1:0] lmask(input int k);
    logic [63:0] m;
    m = (64'd1 << (2*k)) - 64'd1;
    return m[PROD_W-1:0];
  endfunction

  task automatic check_out(input logic [FRAC_W-1:0] a, input logic [FRAC_W-1:0] b);
    logic [PROD_W-1:0] act;
    logic [PROD_W-1:0] e;
    logic [PROD_W-1:0] s;
    logic [PROD_W-1:0] p;
    s = '0;
    for (int k = 0; k < NROW; k++) begin
      act = rows[k*PROD_W +: PROD_W];
      e   = exp_row(a, b, k);
      s   = s + act;
      chk(((act ^ e) & fmask(k)) == '0,
          (digit(b, k) == 0) ? $sformatf("R6 zero field row %0d", k)
                             : $sformatf("R4 R5 field row %0d", k),
          64'(act & fmask(k)), 64'(e & fmask(k)));
      chk(((act ^ e) & pmask(k)) == '0,
          (digit(b, k) == 0) ? $sformatf("R6 prefix row %0d", k)
                             : $sformatf("R8 prefix row %0d", k),
          64'(act & pmask(k)), 64'(e & pmask(k)));
      chk(((act ^ e) & lmask(k)) == '0, $sformatf("R7 low bits row %0d", k),
          64'(act & lmask(k)), 64'(e & lmask(k)));
    end
    chk(rows[(NROW-1)*PROD_W + 24 +: 24] == {1'b1, a}, "R9 top row",
        64'(rows[(NROW-1)*PROD_W + 24 +: 24]), 64'({1'b1, a}));
    p = PROD_W'({1'b1, a}) * PROD_W'({1'b1, b});
    chk(s == p, "R3 row sum", 64'(s), 64'(p));
  endtask

  task automatic step(input logic [FRAC_W-1:0] a, input logic [FRAC_W-1:0] b);
    logic [2*FRAC_W-1:0] e;
    @(negedge clk);
    if (pend.size() > 0) begin
      e = pend.pop_front();
      check_out(e[2*FRAC_W-1:FRAC_W], e[FRAC_W-1:0]);
    end
    fa = a;
    fb = b;
    pend.push_back({a, b});
  endtask

  task automatic flush();
    logic [2*FRAC_W-1:0] e;
    @(negedge clk);
    while (pend.size() > 0) begin
      e = pend.pop_front();
      check_out(e[2*FRAC_W-1:FRAC_W], e[FRAC_W-1:0]);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rows == '0, "R1 reset state", 64'(rows[63:0]), 64'd0);
    rst = 1'b0;

    // Corner and pattern operands
    step(23'h000000, 23'h000000);
    step(23'h7FFFFF, 23'h7FFFFF);
    step(23'h000000, 23'h7FFFFF);
    step(23'h7FFFFF, 23'h000000);
    step(23'h2AAAAA, 23'h555555);
    step(23'h555555, 23'h2AAAAA);
    step(23'h123456, 23'h36DB6D);
    step(23'h654321, 23'h249249);
    step(23'h400001, 23'h1B6DB6);
    for (int i = 0; i < FRAC_W; i++) step(23'h3C0FF0 ^ 23'(i), 23'd1 << i);
    for (int i = 0; i < 300; i++) step(23'($urandom), 23'($urandom));
    flush();

    // R2: output holds between edges
    step(23'h0ABCDE, 23'h5A5A5A);
    step(23'h7F0001, 23'h2D2D2D);
    #2;
    chk(rows[0 +: PROD_W] == exp_row(23'h0ABCDE, 23'h5A5A5A, 0), "R2 hold before edge",
        64'(rows[0 +: PROD_W]), 64'(exp_row(23'h0ABCDE, 23'h5A5A5A, 0)));
    flush();

    // R1: reset in mid-stream clears rows despite active operands
    @(negedge clk);
    rst = 1'b1;
    fa  = 23'h7FFFFF;
    fb  = 23'h555555;
    @(negedge clk);
    chk(rows == '0, "R1 mid-run reset", 64'(rows[63:0]), 64'd0);
    rst = 1'b0;
    for (int i = 0; i < 40; i++) step(23'($urandom), 23'($urandom));
    flush();

    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R2: act=%0d exp=%0d", 0, 1);
      finish_run();
    end
  end

endmodule